// File: doc/BRIEF.md
# Serial Write-Frame Receiver with CRC Gate

This block receives write frames from a serial host. The host pulls the active-low frame-select line low and clocks in data bits, most significant bit first. Each bit is taken on a falling edge of the serial clock. When the host releases frame-select, the number of bits received decides what happens next:

- **24 bits:** the whole frame is a command word and is issued at once as a register update.
- **32 bits:** the first 24 bits are the command word and the last 8 bits are a CRC. The update is issued only if that CRC matches one computed over the word. A mismatch discards the word, sets a sticky packet-error flag and drives an active-low fault output.
- **Any other length:** the frame is dropped.

All serial inputs are oversampled in the system clock domain through two-flop synchronisers. The update is issued as a one-cycle strobe with the 24-bit word beside it. A status-read strobe stands for a read of the status register. It clears the error flag, and the fault output then returns high. Decoding of the command word is left to the consumer of the update strobe.

Top module: `frame_rx`

## Requirements
- R1: A frame of exactly 24 bits, sent MSB first, issues an update whose word is those 24 bits in arrival order, with the first bit at bit 23.
- R2: In a frame of exactly 32 bits, the first 24 bits are the word and the last 8 bits are a received CRC, with its first bit at bit 7. The CRC is CRC-8 with polynomial 0x07 and initial value 0x00, computed MSB first over the 24 word bits. When the received CRC equals the computed one, the word is issued as an update.
- R3: When a 32-bit frame's CRC mismatches, no update is issued, `stat_err` becomes 1 and `fault_n` becomes 0.
- R4: A `status_rd` pulse clears `stat_err` and returns `fault_n` to 1. If a CRC failure and a read land in the same cycle, the flag stays set.
- R5: The error flag is sticky. Later valid frames still issue updates but do not clear the flag.
- R6: A frame whose length is neither 24 nor 32 bits issues no update and leaves `stat_err` unchanged. This covers 0 bits, near misses such as 23, 25, 31 and 33 bits, and frames longer than 63 bits.
- R7: `upd_valid` is high for exactly one clock per accepted frame. `upd_data` holds its value between updates.
- R8: Bits are taken only on serial-clock falling edges while frame-select is low. The bit count restarts each time frame-select falls, so an aborted frame does not disturb the next one.
- R9: After reset, `upd_valid` and `upd_data` are 0, `stat_err` is 0 and `fault_n` is 1.
- R10: The update strobe and the error flag change on the third rising system-clock edge after frame-select goes high, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host; bits are taken on its falling edge |
| csn | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in, MSB first |
| status_rd | input | 1 | One-cycle strobe marking a read of the status register |
| upd_valid | output | 1 | One-cycle register-update strobe |
| upd_data | output | 24 | Command word of the last accepted frame |
| stat_err | output | 1 | Sticky packet-error flag (status register bit) |
| fault_n | output | 1 | Active-low fault output, low while the error flag is set |

## Verification
The bench aims at the following corner cases:

- **Frame lengths one bit either side of 24 and 32, and over 63.** A counter that wraps or compares loosely would issue spurious updates.
- **Frames with a single flipped CRC bit.** A wrong polynomial, bit order or CRC window would let these through, or would reject good frames.
- **A CRC failure that lands in the same cycle as a status read.** A design that lets the read win would lose the error.
- **Good frames that follow an error.** A design that clears the flag on any success would break its stickiness.
- **An aborted short frame followed by a full one.** A design that does not restart the count on frame-select falling would misalign the second word.

Alongside these directed cases, random frames mix all the lengths with random reads. Each update is sampled at its exact latency, so an extra or missing pipeline stage is caught.

// File: rtl/frx_pkg.sv
package frx_pkg;
    localparam int unsigned DATA_W   = 24;
    localparam int unsigned CRC_W    = 8;
    localparam int unsigned FRAME_W  = DATA_W + CRC_W;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
    localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/frx_sync.sv
module frx_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/frx_shift.sv
module frx_shift #(
    parameter int unsigned DATA_W = frx_pkg::DATA_W,
    parameter int unsigned CRC_W  = frx_pkg::CRC_W,
    parameter logic [CRC_W-1:0] POLY = frx_pkg::CRC_POLY,
    localparam int unsigned FRAME_W = DATA_W + CRC_W,
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               bit_en,
    input  logic               bit_in,
    output logic [CNT_W-1:0]   bit_cnt,
    output logic [FRAME_W-1:0] shreg,
    output logic [CRC_W-1:0]   crc_calc
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] DATA_CNT = CNT_W'(DATA_W);

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
        logic [CRC_W-1:0]   crc;
    } shift_st_t;

    shift_st_t st_d, st_q;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    endfunction

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d = '0;
        end else if (bit_en) begin
            st_d.sh = {st_q.sh[FRAME_W-2:0], bit_in};
            if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (st_q.cnt < DATA_CNT) begin
                st_d.crc = crc_step(st_q.crc, bit_in);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_cnt  = st_q.cnt;
    assign shreg    = st_q.sh;
    assign crc_calc = st_q.crc;
endmodule

// File: rtl/frame_rx.sv
module frame_rx #(
    parameter int unsigned DATA_W = frx_pkg::DATA_W,
    parameter int unsigned CRC_W  = frx_pkg::CRC_W,
    parameter logic [CRC_W-1:0] POLY = frx_pkg::CRC_POLY,
    parameter int unsigned SYNC_STAGES = frx_pkg::SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              csn,
    input  logic              sdi,
    input  logic              status_rd,
    output logic              upd_valid,
    output logic [DATA_W-1:0] upd_data,
    output logic              stat_err,
    output logic              fault_n
);
    localparam int unsigned FRAME_W = DATA_W + CRC_W;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] LEN_PLAIN = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LEN_CHECK = CNT_W'(FRAME_W);

    typedef struct packed {
        logic              csn_prev;
        logic              sclk_prev;
        logic              upd_valid;
        logic [DATA_W-1:0] upd_data;
        logic              err;
    } rx_st_t;

    rx_st_t st_d, st_q;

    logic               csn_s, sclk_s, sdi_s;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shreg;
    logic [CRC_W-1:0]   crc_calc;
    logic               csn_rise, csn_fall, bit_en;
    logic               is_plain, is_check, crc_ok, crc_fail, take;
    logic [DATA_W-1:0]  word;

    frx_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({csn, sclk, sdi}),
        .q    ({csn_s, sclk_s, sdi_s})
    );

    frx_shift #(
        .DATA_W(DATA_W),
        .CRC_W (CRC_W),
        .POLY  (POLY)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (csn_fall),
        .bit_en  (bit_en),
        .bit_in  (sdi_s),
        .bit_cnt (bit_cnt),
        .shreg   (shreg),
        .crc_calc(crc_calc)
    );

    always_comb begin
        csn_rise = csn_s & ~st_q.csn_prev;
        csn_fall = ~csn_s & st_q.csn_prev;
        bit_en   = st_q.sclk_prev & ~sclk_s & ~csn_s;

        is_plain = (bit_cnt == LEN_PLAIN);
        is_check = (bit_cnt == LEN_CHECK);
        crc_ok   = (shreg[CRC_W-1:0] == crc_calc);
        crc_fail = csn_rise & is_check & ~crc_ok;
        take     = csn_rise & (is_plain | (is_check & crc_ok));
        word     = is_plain ? shreg[DATA_W-1:0] : shreg[FRAME_W-1:CRC_W];

        st_d           = st_q;
        st_d.csn_prev  = csn_s;
        st_d.sclk_prev = sclk_s;
        st_d.upd_valid = take;
        if (take) begin
            st_d.upd_data = word;
        end
        st_d.err = crc_fail | (st_q.err & ~status_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.csn_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign upd_valid = st_q.upd_valid;
    assign upd_data  = st_q.upd_data;
    assign stat_err  = st_q.err;
    assign fault_n   = ~st_q.err;
endmodule

// File: rtl/frx_checker.sv
module frx_checker #(
    parameter int unsigned DATA_W = frx_pkg::DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_valid,
    input logic [DATA_W-1:0] upd_data,
    input logic              stat_err,
    input logic              status_rd,
    input logic              csn_rise,
    input logic              crc_fail
);
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> !upd_valid);

    a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |-> $stable(upd_data));

    a_r10_update_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(csn_rise));

    a_r3_flag_from_failure: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_err) |-> $past(crc_fail));

    a_r3_no_update_on_failure: assert property (@(posedge clk) disable iff (!rst_n)
        crc_fail |=> !upd_valid);

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_err && !status_rd) |=> stat_err);

    a_r4_set_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_fail && status_rd) |=> stat_err);
endmodule

bind frame_rx frx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_valid(upd_valid),
    .upd_data (upd_data),
    .stat_err (stat_err),
    .status_rd(status_rd),
    .csn_rise (csn_rise),
    .crc_fail (crc_fail)
);

// File: tb/test_frame_rx.sv
`timescale 1ns/1ps
module test_frame_rx;
    localparam int H = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        csn = 1'b1;
    logic        sdi = 1'b0;
    logic        status_rd = 1'b0;
    logic        upd_valid;
    logic [23:0] upd_data;
    logic        stat_err;
    logic        fault_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [23:0] last_data = '0;
    logic        exp_err = 1'b0;

    always #2 clk = ~clk;

    frame_rx i_frame_rx (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .sdi(sdi),
        .status_rd(status_rd), .upd_valid(upd_valid), .upd_data(upd_data),
        .stat_err(stat_err), .fault_n(fault_n)
    );

    function automatic logic [7:0] crc8(input logic [23:0] w);
        logic [7:0] c = 8'h00;
        for (int i = 23; i >= 0; i--) begin
            logic fb = c[7] ^ w[i];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends nbits from bits[nbits-1] down to bits[0], then releases csn and checks
    task automatic frame(input int nbits, input logic [127:0] bits, input bit rd_mid, input string tag);
        bit          exp_upd = 1'b0;
        bit          fail = 1'b0;
        logic [23:0] exp_word = '0;
        if (nbits == 24) begin
            exp_upd = 1'b1; exp_word = bits[23:0];
        end else if (nbits == 32) begin
            exp_word = bits[31:8];
            if (crc8(bits[31:8]) == bits[7:0]) exp_upd = 1'b1;
            else fail = 1'b1;
        end
        csn = 1'b0;
        wait_clks(H);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdi = bits[i];
            wait_clks(H);
            sclk = 1'b1;
            wait_clks(H);
            sclk = 1'b0;
            wait_clks(H);
        end
        wait_clks(H);
        csn = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check({"R10 no early update ", tag}, {31'd0, upd_valid}, 32'd0);
        check({"R10 no early flag change ", tag}, {31'd0, stat_err}, {31'd0, exp_err});
        if (rd_mid) status_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        status_rd = 1'b0;
        exp_err = fail | (exp_err & ~rd_mid);
        if (exp_upd) last_data = exp_word;
        check({"R1/R2/R6 update strobe ", tag}, {31'd0, upd_valid}, {31'd0, exp_upd});
        check({"R1/R2 update word ", tag}, {8'd0, upd_data}, {8'd0, last_data});
        check({"R3/R4/R5 error flag ", tag}, {31'd0, stat_err}, {31'd0, exp_err});
        check({"R3 fault pin ", tag}, {31'd0, fault_n}, {31'd0, ~exp_err});
        @(posedge clk); @(negedge clk);
        check({"R7 single pulse ", tag}, {31'd0, upd_valid}, 32'd0);
        check({"R7 word held ", tag}, {8'd0, upd_data}, {8'd0, last_data});
        wait_clks(4);
    endtask

    task automatic read_status(input string tag);
        status_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        status_rd = 1'b0;
        exp_err = 1'b0;
        check({"R4 flag cleared ", tag}, {31'd0, stat_err}, 32'd0);
        check({"R4 fault released ", tag}, {31'd0, fault_n}, 32'd1);
        wait_clks(2);
    endtask

    function automatic logic [127:0] chk_frame(input logic [23:0] w, input logic [7:0] flip);
        return {96'd0, w, crc8(w) ^ flip};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [23:0] w;
        void'($urandom(32'd20240611));
        wait_clks(5);
        check("R9 reset strobe", {31'd0, upd_valid}, 32'd0);
        check("R9 reset fault", {31'd0, fault_n}, 32'd1);
        rst_n = 1'b1;
        wait_clks(3);
        check("R9 strobe", {31'd0, upd_valid}, 32'd0);
        check("R9 word", {8'd0, upd_data}, 32'd0);
        check("R9 flag", {31'd0, stat_err}, 32'd0);
        check("R9 fault", {31'd0, fault_n}, 32'd1);

        frame(24, 128'hA5C3F0, 1'b0, "R1 plain");
        frame(24, 128'h000001, 1'b0, "R1 lsb only");
        frame(32, chk_frame(24'h123456, 8'h00), 1'b0, "R2 good crc");
        frame(32, chk_frame(24'hFFFFFF, 8'h00), 1'b0, "R2 all ones");
        frame(32, chk_frame(24'hC0FFEE, 8'h01), 1'b0, "R3 bad crc lsb");
        frame(24, 128'h5A5A5A, 1'b0, "R5 plain after error");
        frame(32, chk_frame(24'h0F0F0F, 8'h00), 1'b0, "R5 good crc after error");
        read_status("R4 read");
        frame(32, chk_frame(24'hBEEF01, 8'h80), 1'b1, "R4 fail with read");
        read_status("R4 read after collision");
        frame(32, chk_frame(24'h777777, 8'h00), 1'b1, "R4 read during good frame");
        frame(0, 128'd0, 1'b0, "R6 empty");
        frame(23, 128'h7FFFFF, 1'b0, "R6 23 bits");
        frame(25, 128'h1ABCDEF, 1'b0, "R6 25 bits");
        frame(32, chk_frame(24'h010203, 8'h10), 1'b0, "R3 bad crc mid");
        frame(31, chk_frame(24'h111111, 8'h00) >> 1, 1'b0, "R6 31 bits");
        frame(33, chk_frame(24'h222222, 8'h00) << 1, 1'b0, "R6 33 bits");
        frame(70, {$urandom, $urandom, $urandom, $urandom}, 1'b0, "R6 70 bits");
        read_status("R4 read before abort test");
        frame(10, 128'h3FF, 1'b0, "R8 aborted short");
        frame(24, 128'h9E3779, 1'b0, "R8 after abort");

        for (int n = 0; n < 150; n++) begin
            int kind = $urandom_range(0, 9);
            bit rd = ($urandom_range(0, 7) == 0);
            w = 24'($urandom);
            if (kind <= 2) frame(24, {104'd0, w}, rd, "R1 random");
            else if (kind <= 5) frame(32, chk_frame(w, 8'h00), rd, "R2 random");
            else if (kind <= 7) frame(32, chk_frame(w, 8'(1 << $urandom_range(0, 7))), rd, "R3 random");
            else if (kind == 8) begin
                int len = $urandom_range(0, 40);
                if (len == 24 || len == 32) len = len + 1;
                frame(len, {$urandom, $urandom, $urandom, $urandom}, rd, "R6 random");
            end else read_status("R4 random read");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule